// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns parallel characters into asynchronous serial frames on a single output line. A character enters through a valid/ready stream port and lands in a holding buffer. It then moves into a separate shift register that drives the line. Because there are two registers, the next character can be accepted while the current frame is still on the wire, so frames can follow one another with no idle gap.

Each frame has a low start bit, the data bits least significant first, an optional parity bit, and high stop bits. The frame format is held in a control register that loads when a strobe is pulsed. The format covers word length (5 to 8 bits), parity on or off, parity sense, and one or two stop bits. With a 5-bit word, the two-stop setting gives one and a half stop bits instead.

All bit timing comes from `tick16`, a clock enable at sixteen times the bit rate. A bit lasts 16 ticks and a half bit lasts 8.

Stream rules on the data port:
- A character is accepted on a rising clock edge where both `in_valid` and `in_ready` are high.
- `in_ready` is the buffer-empty flag. It stays low from the cycle after an accept until the character moves into the shift register.
- The source may hold `in_valid` high for any length of time. While `in_ready` is low, `in_valid` and `in_data` are not sampled.

Top module: `uart_frame_tx`

## Requirements
- R1: The word length code `cfg_wlen` selects 5 + code data bits (0→5, 1→6, 2→7, 3→8). Data is sent least significant bit first. Bits of `in_data` above the selected length are never sent.
- R2: `txd` rests at 1 when no frame is in progress, and every frame begins with one start bit at 0.
- R3: With parity on, a parity bit follows the last data bit. With `cfg_par_odd`=1 the data bits plus the parity bit hold an odd number of ones; with 0 they hold an even number.
- R4: With `cfg_par_en`=0 no parity bit is sent, and the first stop bit directly follows the last data bit.
- R5: Stop bits are 1. With `cfg_stop2`=0 the stop time is 16 ticks. With `cfg_stop2`=1 it is 32 ticks, or 24 ticks when the word code is 0 (5 bits).
- R6: `in_ready` is 1 while the holding buffer is empty. An accepted character clears `in_ready` on the next cycle. `in_valid` pulses while `in_ready` is 0 have no effect on the characters sent.
- R7: A buffered character moves to the shift register on the next `tick16` edge when the line is idle. If the buffer is full when the last stop tick ends, the next start bit begins on that same edge with no gap. `line_empty` is 1 only when both the buffer and the shift register are empty.
- R8: The format pins are captured only on a cycle with `cfg_load`=1 and are ignored otherwise. Each frame uses the format held when its character moved into the shift register, so a format change during a frame does not alter that frame.
- R9: Reset (`rst_n`=0) sets `txd`=1, `in_ready`=1 and `line_empty`=1, aborts any frame, and restores the format 8 data bits, no parity, 1 stop bit.
- R10: Each start, data and parity bit lasts exactly 16 ticks, and `txd` changes only on clock edges where `tick16` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| tick16 | input | 1 | Clock enable at 16x the bit rate |
| in_data | input | 8 | Character to send |
| in_valid | input | 1 | Character on `in_data` is valid |
| in_ready | output | 1 | Holding buffer empty; a character can be accepted |
| cfg_wlen | input | 2 | Word length code (5 + code bits) |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop2 | input | 1 | Two stop bits (1.5 for 5-bit words) |
| cfg_load | input | 1 | Capture the format pins |
| txd | output | 1 | Serial line output |
| line_empty | output | 1 | Buffer and shift register both empty |

## Verification
The hardest cases to reach are two boundaries that fall on the same clock edge:
- a character is accepted on exactly the tick edge that ends a frame, which must not produce a back-to-back start;
- a 1.5-stop frame is followed immediately by the next start bit.

The bench drives `tick16` with a fixed phase and records the clock edge of every accept. Random gaps then move accepts across the frame boundary, and the stamped accept time decides whether an immediate next start is expected. Format changes are issued while a frame is still shifting, so the snapshot rule is tested under load.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int WLEN_W = 2;

  typedef struct packed {
    logic [WLEN_W-1:0] wlen;
    logic              par_en;
    logic              par_odd;
    logic              stop2;
  } fmt_t;

  localparam fmt_t FMT_RESET = '{wlen: 2'd3, par_en: 1'b0, par_odd: 1'b0, stop2: 1'b0};

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;
endpackage

// File: rtl/uart_tx_fmt_reg.sv
module uart_tx_fmt_reg
  import uart_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  fmt_t fmt_in,
  output fmt_t fmt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= FMT_RESET;
    end else if (load) begin
      fmt_q <= fmt_in;
    end
  end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data_q
);
  logic accept;

  assign in_ready = !full;
  assign accept   = in_valid && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      data_q <= '0;
    end else if (accept) begin
      full   <= 1'b1;
      data_q <= in_data;
    end else if (take) begin
      full   <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MIN_W  = 5
) (
  input  logic [DATA_W-1:0] data,
  input  fmt_t              fmt,
  output logic              par_bit
);
  localparam int LEN_W = $clog2(DATA_W + 1);

  logic [LEN_W-1:0]  nbits;
  logic [DATA_W-1:0] mask;

  assign nbits = LEN_W'(MIN_W) + LEN_W'(fmt.wlen);

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = (LEN_W'(i) < nbits);
  end

  assign par_bit = (^(data & mask)) ^ fmt.par_odd;
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int MIN_W      = 5,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  fmt_t              fmt,
  input  logic              par_in,
  output logic              take,
  output logic              txd,
  output logic              idle
);
  localparam int CNT_W  = $clog2(OVERSAMPLE);
  localparam int HALF   = OVERSAMPLE / 2;
  localparam int BIDX_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF - 1);

  tx_state_e          state;
  logic [CNT_W-1:0]   cnt;
  logic [DATA_W-1:0]  sreg;
  logic [BIDX_W-1:0]  bits_left;
  logic               par_q;
  logic               par_en_q;
  logic [2:0]         halves;

  logic [BIDX_W-1:0]  nbits_new;
  logic [2:0]         halves_new;
  logic               frame_end;

  always_comb begin
    nbits_new = BIDX_W'(MIN_W) + BIDX_W'(fmt.wlen);
    if (!fmt.stop2)          halves_new = 3'd2;
    else if (fmt.wlen == '0) halves_new = 3'd3;
    else                     halves_new = 3'd4;
  end

  assign frame_end = tick && (state == ST_STOP) && (cnt == HALF_LAST) && (halves == 3'd1);
  assign take      = hold_full && tick && ((state == ST_IDLE) || frame_end);
  assign idle      = (state == ST_IDLE);

  always_comb begin
    case (state)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = sreg[0];
      ST_PAR:   txd = par_q;
      default:  txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      sreg      <= '0;
      bits_left <= '0;
      par_q     <= 1'b0;
      par_en_q  <= 1'b0;
      halves    <= 3'd0;
    end else if (take) begin
      state     <= ST_START;
      cnt       <= '0;
      sreg      <= hold_data;
      bits_left <= nbits_new;
      par_q     <= par_in;
      par_en_q  <= fmt.par_en;
      halves    <= halves_new;
    end else if (tick) begin
      case (state)
        ST_START: begin
          if (cnt == BIT_LAST) begin
            state <= ST_DATA;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt == BIT_LAST) begin
            cnt       <= '0;
            sreg      <= sreg >> 1;
            bits_left <= bits_left - 1'b1;
            if (bits_left == BIDX_W'(1)) begin
              state <= par_en_q ? ST_PAR : ST_STOP;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (cnt == BIT_LAST) begin
            state <= ST_STOP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt == HALF_LAST) begin
            cnt <= '0;
            if (halves == 3'd1) state <= ST_IDLE;
            else                halves <= halves - 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int MIN_W      = 5,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  input  logic              cfg_load,
  output logic              txd,
  output logic              line_empty
);
  fmt_t              fmt_in;
  fmt_t              fmt_q;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              take;
  logic              par_bit;
  logic              sh_idle;

  assign fmt_in = '{wlen: cfg_wlen, par_en: cfg_par_en, par_odd: cfg_par_odd, stop2: cfg_stop2};

  uart_tx_fmt_reg u_fmt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (cfg_load),
    .fmt_in (fmt_in),
    .fmt_q  (fmt_q)
  );

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .take     (take),
    .full     (hold_full),
    .data_q   (hold_data)
  );

  uart_tx_parity #(.DATA_W(DATA_W), .MIN_W(MIN_W)) u_par (
    .data    (hold_data),
    .fmt     (fmt_q),
    .par_bit (par_bit)
  );

  uart_tx_shift #(.DATA_W(DATA_W), .MIN_W(MIN_W), .OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick16),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .fmt       (fmt_q),
    .par_in    (par_bit),
    .take      (take),
    .txd       (txd),
    .idle      (sh_idle)
  );

  assign line_empty = sh_idle && !hold_full;
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic in_valid,
  input logic in_ready,
  input logic txd,
  input logic line_empty
);
  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_MARK: assert (txd && in_ready && line_empty); // R9
    end
  end

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    line_empty |-> txd); // R2

  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R6

  AST_FILL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid)); // R6

  AST_LINE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    line_empty |-> in_ready); // R7

  AST_TXD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick16 |=> $stable(txd)); // R10
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick16     (tick16),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .txd        (txd),
  .line_empty (line_empty)
);

// File: tb/uart_frame_tx_tb.sv
`timescale 1ns/1ps
module uart_frame_tx_tb;
  typedef struct {
    logic [7:0]  d;
    logic [1:0]  wlen;
    logic        pe;
    logic        po;
    logic        s2;
    int unsigned stamp;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] cfg_wlen = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_stop2 = 1'b0;
  logic       cfg_load = 1'b0;
  logic       txd;
  logic       line_empty;

  int checks = 0;
  int errors = 0;
  int unsigned edge_no = 0;
  int tdiv = 0;
  logic [1:0] m_wlen = 2'd3;
  logic       m_pe = 1'b0, m_po = 1'b0, m_s2 = 1'b0;
  item_t q[$];
  item_t cur;
  bit    in_frame = 0;
  int    ticks = 0;

  uart_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .cfg_wlen(cfg_wlen),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2),
    .cfg_load(cfg_load), .txd(txd), .line_empty(line_empty)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) edge_no++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic int nb(item_t it);
    return 5 + int'(it.wlen);
  endfunction
  function automatic int t_stop(item_t it);
    return 16 * (1 + nb(it) + (it.pe ? 1 : 0));
  endfunction
  function automatic int t_frame(item_t it);
    int s;
    if (!it.s2) s = 16;
    else if (it.wlen == 2'd0) s = 24;
    else s = 32;
    return t_stop(it) + s;
  endfunction
  function automatic logic exp_bit(item_t it, int k);
    int ones = 0;
    if (k == 0) return 1'b0;
    if (k <= nb(it)) return it.d[k-1];
    for (int i = 0; i < nb(it); i++) ones += it.d[i];
    return logic'(ones % 2) ^ it.po;
  endfunction

  // tick generation and line monitor
  always @(negedge clk) begin
    bit fired;
    fired = tick16;
    if (!rst_n) begin
      in_frame = 0;
      ticks = 0;
    end else if (in_frame) begin
      if (fired) begin
        ticks++;
        if (ticks < t_stop(cur) && ticks % 16 == 8) begin
          int k;
          k = ticks / 16;
          if (k == 0) chk(txd == 1'b0, "R2 start bit", txd, 0);
          else if (k <= nb(cur)) chk(txd == exp_bit(cur, k), "R1 data bit", txd, exp_bit(cur, k));
          else chk(txd == exp_bit(cur, k), "R3 parity bit", txd, exp_bit(cur, k));
        end
        if (ticks == t_stop(cur) + 8)
          chk(txd == 1'b1, cur.pe ? "R5 first stop" : "R4 stop after data", txd, 1);
        if (ticks == t_frame(cur) - 1)
          chk(txd == 1'b1 && line_empty == 1'b0, "R5 stop held to last tick", {txd, line_empty}, 2);
        if (ticks == t_frame(cur)) begin
          if (q.size() > 0 && q[0].stamp < edge_no) begin
            chk(txd == 1'b0, "R7 back-to-back start", txd, 0);
            cur = q.pop_front();
            ticks = 0;
          end else begin
            chk(txd == 1'b1, "R5 stop length end", txd, 1);
            if (q.size() == 0) chk(line_empty == 1'b1, "R7 line empty after frame", line_empty, 1);
            in_frame = 0;
          end
        end
      end
    end else if (txd == 1'b0) begin
      if (q.size() == 0) begin
        chk(1'b0, "R6 unexpected frame", 0, 1);
      end else begin
        cur = q.pop_front();
        in_frame = 1;
        ticks = 0;
      end
    end
    tdiv = (tdiv == 2) ? 0 : tdiv + 1;
    tick16 = (tdiv == 0);
  end

  task automatic wait_ready();
    @(posedge clk); #1;
    while (!in_ready) begin @(posedge clk); #1; end
  endtask

  task automatic send(input logic [7:0] d);
    item_t it;
    wait_ready();
    in_data = d;
    in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    it = '{d: d, wlen: m_wlen, pe: m_pe, po: m_po, s2: m_s2, stamp: edge_no};
    q.push_back(it);
    chk(in_ready == 1'b0, "R6 ready drops after accept", in_ready, 0);
    in_data = $urandom;
  endtask

  task automatic set_cfg(input logic [1:0] w, input logic pe, input logic po, input logic s2);
    wait_ready();
    cfg_wlen = w; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2;
    cfg_load = 1'b1;
    @(posedge clk); #1;
    cfg_load = 1'b0;
    m_wlen = w; m_pe = pe; m_po = po; m_s2 = s2;
    // R8: scramble pins without a load strobe; the latched format must hold
    cfg_wlen = 2'($urandom); cfg_par_en = 1'($urandom);
    cfg_par_odd = 1'($urandom); cfg_stop2 = 1'($urandom);
  endtask

  task automatic drain();
    @(posedge clk); #1;
    while (!(line_empty && q.size() == 0 && !in_frame)) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1;
    chk(txd == 1'b1 && in_ready == 1'b1 && line_empty == 1'b1, "R9 reset state", {txd, in_ready, line_empty}, 7);
    rst_n = 1'b1;

    // R9 default format 8N1, R7 back-to-back pair
    send(8'h35);
    send(8'hCA);
    drain();
    // R5 1.5 stop with 5-bit words, R1 upper bits dropped, R3 even parity
    set_cfg(2'd0, 1'b1, 1'b0, 1'b1);
    send(8'hFF);
    send(8'hE5);
    drain();
    // R3 odd parity, 6 bits, two stop bits
    set_cfg(2'd1, 1'b1, 1'b1, 1'b1);
    send(8'h00);
    send(8'h2A);
    drain();
    // R4 parity off, 7 bits, two stop bits
    set_cfg(2'd2, 1'b0, 1'b0, 1'b1);
    send(8'h7F);
    // R6 valid while buffer full is ignored
    send(8'h11);
    in_data = 8'hA5; in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R6 ignored valid keeps buffer", in_ready, 0);
    drain();
    // R8 format change while a frame shifts out
    send(8'h96);
    @(posedge clk); #1;
    while (txd) begin @(posedge clk); #1; end
    set_cfg(2'd3, 1'b1, 1'b1, 1'b0);
    send(8'h69);
    drain();

    // random mix
    for (int n = 0; n < 45; n++) begin
      if ($urandom_range(0, 3) == 0)
        set_cfg(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      send(8'($urandom));
      if ($urandom_range(0, 2) == 0) repeat ($urandom_range(0, 400)) @(posedge clk);
    end
    drain();

    // R9 reset during a frame
    send(8'h5A);
    @(posedge clk); #1;
    while (txd) begin @(posedge clk); #1; end
    repeat (40) @(posedge clk);
    #1;
    rst_n = 1'b0;
    q.delete();
    @(posedge clk); #1;
    chk(txd == 1'b1 && in_ready == 1'b1 && line_empty == 1'b1, "R9 reset aborts frame", {txd, in_ready, line_empty}, 7);
    m_wlen = 2'd3; m_pe = 1'b0; m_po = 1'b0; m_s2 = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    send(8'hC3);
    drain();
    report();
  end
endmodule